// File: doc/BRIEF.md
# NAND Page Parity Accumulator

This block sits beside the byte data path of a NAND flash controller and builds a single-error-correcting Hamming-style code over the bytes moved through the data register. While it is accumulating, each byte that goes out to the flash or comes back from it is folded into the parity of the 256-byte chunk it falls in. Each chunk produces three parity bytes, so a two-chunk page of 512 bytes produces six.

Software drives the block through a 2-bit mode field. The values select off, accumulate, readout and clear. To start a page, software writes clear, then off, then accumulate, and then moves the data. To collect the result, it writes off and then readout. Each data-register read then returns the next parity byte, and the flash is not strobed. Software compares the stored parity with the freshly computed parity to locate and fix a flipped bit. Correction itself is done outside this block.

Top module: `nand_ecc_accum`

## Requirements
- R1: After reset the mode is off (`mode_out` = 2'b00), and with no read strobe applied `flash_rd_strobe` is low.
- R2: A write on `mode_wr` loads `mode_in` into `mode_out` at the next clock. The encoding is 2'b00 off, 2'b01 accumulate, 2'b10 readout, 2'b11 clear.
- R3: While the mode is off, bytes strobed by `dat_wr` or `dat_rd` change neither the parity nor the byte count.
- R4: In accumulate mode every byte strobed by `dat_wr` or `dat_rd` (value on `dat_in`) is folded into its chunk's parity. The code has 16 line-parity bits and 6 column-parity bits. Bit 2k+1 of the line parity covers bytes whose offset bit k is 1, and bit 2k covers those where it is 0. The column bits cp0..cp5 cover data bits {0,2,4,6}, {1,3,5,7}, {0,1,4,5}, {2,3,6,7}, {0,1,2,3} and {4,5,6,7}. All 24 bits are stored inverted. The low byte is line bits 7:0, the middle byte is line bits 15:8, and the high byte is {cp5..cp0, 1, 1}.
- R5: A page of all-0xFF data yields six parity bytes of 0xFF.
- R6: The first 256 accumulated bytes feed chunk 0 and the next 256 feed chunk 1. Bytes after the 512th are ignored until the next clear.
- R7: In readout mode successive reads present, for chunk 0 and then chunk 1, the middle byte, then the low byte, then the high byte on `ecc_byte`. `ecc_byte` shows the byte that the next read consumes.
- R8: The readout position advances by one per read and wraps from the sixth byte back to the first. Writing readout mode restarts it at the first byte.
- R9: In readout mode `flash_rd_strobe` stays low. In every other mode it follows `dat_rd`.
- R10: A write of clear mode resets both chunk parities and the byte count within one clock, so an immediate readout returns all 0xFF.
- R11: A single flipped data bit in a chunk changes exactly 11 of that chunk's 24 parity bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_wr | input | 1 | Mode field write strobe |
| mode_in | input | 2 | Mode value being written |
| dat_wr | input | 1 | Data register write strobe (byte going to flash) |
| dat_rd | input | 1 | Data register read strobe |
| dat_in | input | 8 | Byte moved through the data register this cycle |
| mode_out | output | 2 | Current mode |
| ecc_byte | output | 8 | Parity byte returned by the next readout read |
| flash_rd_strobe | output | 1 | Read strobe passed to the flash |

## Verification
The bench targets the chunk boundary at byte 256 and the saturation at byte 512. A design that switches chunks one byte late, or keeps counting after byte 512, puts a byte into the wrong triple, and the readout comparison catches it. It also checks the permuted order inside each triple and the wrap after six reads, where a wrong order or a missed wrap returns the wrong byte. Other cases it covers are clearing with no data, an erased page, traffic in off mode, and one flipped bit. A design that leaks off-mode bytes, clears late or computes a wrong parity map shows a mismatch, or a flipped-bit distance other than 11.

// File: rtl/nand_ecc_pkg.sv
package nand_ecc_pkg;
  typedef enum logic [1:0] {
    MODE_OFF  = 2'b00,
    MODE_ACC  = 2'b01,
    MODE_READ = 2'b10,
    MODE_CLR  = 2'b11
  } ecc_mode_e;

  localparam int CHUNK_BYTES = 256;
  localparam int OFFS_W      = 8;
  localparam int PAR_W       = 24;
endpackage

// File: rtl/ecc_mode_ctrl.sv
module ecc_mode_ctrl
  import nand_ecc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr,
  input  logic [1:0] wval,
  output ecc_mode_e mode,
  output logic      clr_now,
  output logic      rd_restart
);
  ecc_mode_e mode_d, mode_q;

  always_comb begin
    mode_d = mode_q;
    if (wr) mode_d = ecc_mode_e'(wval);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= MODE_OFF;
    else        mode_q <= mode_d;
  end

  assign mode       = mode_q;
  assign clr_now    = wr && (ecc_mode_e'(wval) == MODE_CLR);
  assign rd_restart = wr && (ecc_mode_e'(wval) == MODE_READ);
endmodule

// File: rtl/ecc_chunk_acc.sv
module ecc_chunk_acc
  import nand_ecc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic [OFFS_W-1:0] offs,
  input  logic [7:0]        data,
  output logic [PAR_W-1:0]  par
);
  // Compact state: xor of all data, xor of byte parities per set offset bit, total parity
  logic [7:0]        colx_d, colx_q;
  logic [OFFS_W-1:0] lodd_d, lodd_q;
  logic              tot_d, tot_q;
  logic              bpar;

  assign bpar = ^data;

  always_comb begin
    colx_d = colx_q;
    lodd_d = lodd_q;
    tot_d  = tot_q;
    if (clr) begin
      colx_d = '0;
      lodd_d = '0;
      tot_d  = 1'b0;
    end else if (en) begin
      colx_d = colx_q ^ data;
      tot_d  = tot_q ^ bpar;
      lodd_d = lodd_q ^ (bpar ? offs : '0);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      colx_q <= '0;
      lodd_q <= '0;
      tot_q  <= 1'b0;
    end else begin
      colx_q <= colx_d;
      lodd_q <= lodd_d;
      tot_q  <= tot_d;
    end
  end

  logic [5:0]          cp;
  logic [2*OFFS_W-1:0] lp;

  assign cp[0] = ^(colx_q & 8'h55);
  assign cp[1] = ^(colx_q & 8'hAA);
  assign cp[2] = ^(colx_q & 8'h33);
  assign cp[3] = ^(colx_q & 8'hCC);
  assign cp[4] = ^(colx_q & 8'h0F);
  assign cp[5] = ^(colx_q & 8'hF0);

  for (genvar k = 0; k < OFFS_W; k++) begin : g_line
    assign lp[2*k+1] = lodd_q[k];
    assign lp[2*k]   = tot_q ^ lodd_q[k];
  end

  // {high, middle, low}, inverted so an erased chunk reads all ones
  assign par = ~{cp, 2'b00, lp};
endmodule

// File: rtl/ecc_readout.sv
module ecc_readout
  import nand_ecc_pkg::*;
#(
  parameter int CHUNKS = 2,
  localparam int SEL_W = (CHUNKS > 1) ? $clog2(CHUNKS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    restart,
  input  logic                    step,
  input  logic [CHUNKS*PAR_W-1:0] par_all,
  output logic [7:0]              byte_o,
  output logic [1:0]              pos_o,
  output logic [SEL_W-1:0]        chk_o
);
  logic [1:0]       pos_d, pos_q;
  logic [SEL_W-1:0] chk_d, chk_q;
  logic [PAR_W-1:0] sel;

  always_comb begin
    pos_d = pos_q;
    chk_d = chk_q;
    if (restart) begin
      pos_d = '0;
      chk_d = '0;
    end else if (step) begin
      if (pos_q == 2'd2) begin
        pos_d = '0;
        chk_d = (chk_q == SEL_W'(CHUNKS - 1)) ? '0 : chk_q + 1'b1;
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
      chk_q <= '0;
    end else begin
      pos_q <= pos_d;
      chk_q <= chk_d;
    end
  end

  assign sel = par_all[chk_q*PAR_W +: PAR_W];

  // Order within a triple: middle, low, high
  always_comb begin
    case (pos_q)
      2'd0:    byte_o = sel[15:8];
      2'd1:    byte_o = sel[7:0];
      default: byte_o = sel[23:16];
    endcase
  end

  assign pos_o = pos_q;
  assign chk_o = chk_q;
endmodule

// File: rtl/nand_ecc_accum.sv
module nand_ecc_accum
  import nand_ecc_pkg::*;
#(
  parameter int CHUNKS = 2,
  localparam int PAGE_BYTES = CHUNKS * CHUNK_BYTES,
  localparam int CNT_W      = $clog2(PAGE_BYTES + 1),
  localparam int SEL_W      = (CHUNKS > 1) ? $clog2(CHUNKS) : 1,
  localparam int HI_W       = CNT_W - OFFS_W
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_wr,
  input  logic [1:0] mode_in,
  input  logic       dat_wr,
  input  logic       dat_rd,
  input  logic [7:0] dat_in,
  output logic [1:0] mode_out,
  output logic [7:0] ecc_byte,
  output logic       flash_rd_strobe
);
  ecc_mode_e mode;
  logic      clr_now, rd_restart;

  ecc_mode_ctrl u_mode (
    .clk(clk), .rst_n(rst_n), .wr(mode_wr), .wval(mode_in),
    .mode(mode), .clr_now(clr_now), .rd_restart(rd_restart)
  );

  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic             room, fire;

  assign room = (cnt_q < CNT_W'(PAGE_BYTES));
  assign fire = (mode == MODE_ACC) && (dat_wr || dat_rd) && room;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_now)   cnt_d = '0;
    else if (fire) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  logic [CHUNKS*PAR_W-1:0] par_all;

  for (genvar i = 0; i < CHUNKS; i++) begin : g_chunk
    logic en_i;
    assign en_i = fire && (cnt_q[CNT_W-1:OFFS_W] == HI_W'(i));
    ecc_chunk_acc u_acc (
      .clk(clk), .rst_n(rst_n), .clr(clr_now), .en(en_i),
      .offs(cnt_q[OFFS_W-1:0]), .data(dat_in),
      .par(par_all[i*PAR_W +: PAR_W])
    );
  end

  logic             rd_step;
  logic [1:0]       rd_pos;
  logic [SEL_W-1:0] rd_chk;

  assign rd_step = (mode == MODE_READ) && dat_rd;

  ecc_readout #(.CHUNKS(CHUNKS)) u_rdout (
    .clk(clk), .rst_n(rst_n), .restart(rd_restart || clr_now),
    .step(rd_step), .par_all(par_all),
    .byte_o(ecc_byte), .pos_o(rd_pos), .chk_o(rd_chk)
  );

  assign mode_out        = mode;
  assign flash_rd_strobe = dat_rd && (mode != MODE_READ);
endmodule

// File: rtl/nand_ecc_accum_chk.sv
module nand_ecc_accum_chk #(
  parameter int PAGE_BYTES = 512,
  parameter int CNT_W      = 10,
  parameter int SEL_W      = 1,
  parameter int CHUNKS     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mode_wr,
  input logic [1:0]       mode_in,
  input logic [1:0]       mode_out,
  input logic             dat_rd,
  input logic             flash_rd_strobe,
  input logic [CNT_W-1:0] cnt,
  input logic [1:0]       pos,
  input logic [SEL_W-1:0] chk
);
  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    mode_wr |=> mode_out == $past(mode_in)); // R2

  AST_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 2'b00 && !mode_wr) |=> $stable(cnt)); // R3

  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(PAGE_BYTES)); // R6

  AST_POS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= 2'd2 && chk <= SEL_W'(CHUNKS - 1)); // R8

  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 2'b10 && dat_rd && !mode_wr && pos == 2'd2 && chk == SEL_W'(CHUNKS - 1))
      |=> (pos == 2'd0 && chk == '0)); // R8

  AST_NO_FLASH_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_out == 2'b10) |-> !flash_rd_strobe); // R9

  AST_CLEAR_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_wr && mode_in == 2'b11) |=> cnt == '0); // R10
endmodule

bind nand_ecc_accum nand_ecc_accum_chk #(
  .PAGE_BYTES(PAGE_BYTES), .CNT_W(CNT_W), .SEL_W(SEL_W), .CHUNKS(CHUNKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
  .mode_out(mode_out), .dat_rd(dat_rd), .flash_rd_strobe(flash_rd_strobe),
  .cnt(cnt_q), .pos(rd_pos), .chk(rd_chk)
);

// File: tb/nand_ecc_accum_tb.sv
module nand_ecc_accum_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_wr = 1'b0;
  logic [1:0] mode_in = 2'b00;
  logic       dat_wr = 1'b0;
  logic       dat_rd = 1'b0;
  logic [7:0] dat_in = 8'h00;
  logic [1:0] mode_out;
  logic [7:0] ecc_byte;
  logic       flash_rd_strobe;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  page [512];
  logic [7:0]  got [6];

  always #4 clk = ~clk;

  nand_ecc_accum u_dut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .dat_wr(dat_wr), .dat_rd(dat_rd), .dat_in(dat_in),
    .mode_out(mode_out), .ecc_byte(ecc_byte), .flash_rd_strobe(flash_rd_strobe)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference parity for one chunk over the first n bytes of page: {high, middle, low}
  function automatic logic [23:0] ref_par(int chunk, int n);
    logic [15:0] lp = '0;
    logic [5:0]  cp = '0;
    for (int i = chunk * 256; i < chunk * 256 + 256 && i < n; i++) begin
      logic [7:0] d = page[i];
      int a = i - chunk * 256;
      logic bp = ^d;
      for (int k = 0; k < 8; k++) begin
        if (((a >> k) & 1) == 1) lp[2*k+1] ^= bp;
        else                     lp[2*k]   ^= bp;
      end
      cp[0] ^= d[0] ^ d[2] ^ d[4] ^ d[6];
      cp[1] ^= d[1] ^ d[3] ^ d[5] ^ d[7];
      cp[2] ^= d[0] ^ d[1] ^ d[4] ^ d[5];
      cp[3] ^= d[2] ^ d[3] ^ d[6] ^ d[7];
      cp[4] ^= d[0] ^ d[1] ^ d[2] ^ d[3];
      cp[5] ^= d[4] ^ d[5] ^ d[6] ^ d[7];
    end
    return ~{cp, 2'b00, lp};
  endfunction

  function automatic logic [7:0] exp_byte(int k, int n);
    logic [23:0] p = ref_par(k / 3, n);
    case (k % 3)
      0:       return p[15:8];
      1:       return p[7:0];
      default: return p[23:16];
    endcase
  endfunction

  task automatic set_mode(logic [1:0] m);
    @(negedge clk);
    mode_wr = 1'b1; mode_in = m;
    @(negedge clk);
    mode_wr = 1'b0;
  endtask

  task automatic move_byte(logic [7:0] b, bit as_read);
    @(negedge clk);
    dat_in = b;
    if (as_read) dat_rd = 1'b1; else dat_wr = 1'b1;
    #1;
    if (as_read) chk("R9 strobe outside readout", 32'(flash_rd_strobe), 32'd1);
    @(negedge clk);
    dat_rd = 1'b0; dat_wr = 1'b0;
  endtask

  // One readout read: sample presented byte, then consume it
  task automatic read_one(output logic [7:0] v);
    @(negedge clk);
    v = ecc_byte;
    dat_rd = 1'b1;
    #1;
    chk("R9 no flash strobe in readout", 32'(flash_rd_strobe), 32'd0);
    @(negedge clk);
    dat_rd = 1'b0;
  endtask

  task automatic read_six(string req, int n);
    logic [7:0] v;
    set_mode(2'b00);
    set_mode(2'b10);
    for (int k = 0; k < 6; k++) begin
      read_one(v);
      got[k] = v;
      chk(req, 32'(v), 32'(exp_byte(k, n)));
    end
  endtask

  task automatic fill_acc(int n);
    set_mode(2'b11);
    set_mode(2'b00);
    set_mode(2'b01);
    for (int i = 0; i < n; i++) move_byte(page[i], bit'($urandom_range(0, 1)));
  endtask

  initial begin
    logic [7:0] v;
    logic [23:0] orig, now;
    void'($urandom(32'h5EED_0042));

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset mode", 32'(mode_out), 32'd0);
    chk("R1 strobe idle", 32'(flash_rd_strobe), 32'd0);

    // R10: clear then read with no data -> all ones
    set_mode(2'b11);
    chk("R2 mode reads clear", 32'(mode_out), 32'd3);
    for (int i = 0; i < 512; i++) page[i] = 8'h00;
    read_six("R10 cleared parity", 0);
    chk("R2 mode reads readout", 32'(mode_out), 32'd2);

    // Random full pages (R4, R7)
    for (int t = 0; t < 3; t++) begin
      for (int i = 0; i < 512; i++) page[i] = 8'($urandom);
      fill_acc(512);
      read_six("R4 R7 random page", 512);
    end
    // R8: wrap without re-entering readout
    for (int k = 0; k < 6; k++) begin
      read_one(v);
      chk("R8 wrap", 32'(v), 32'(exp_byte(k, 512)));
    end
    // R8: partial read then re-entry restarts at first byte
    read_one(v);
    read_one(v);
    read_six("R8 restart on readout entry", 512);

    // R3: off-mode traffic leaves parity untouched
    set_mode(2'b00);
    for (int i = 0; i < 16; i++) move_byte(8'($urandom), bit'(i & 1));
    read_six("R3 off mode ignored", 512);

    // R6: accumulate past 512 bytes without clearing is ignored
    set_mode(2'b00);
    set_mode(2'b01);
    for (int i = 0; i < 8; i++) move_byte(8'($urandom), 1'b0);
    read_six("R6 saturate after 512", 512);

    // R5: erased page
    for (int i = 0; i < 512; i++) page[i] = 8'hFF;
    fill_acc(512);
    read_six("R5 erased page", 512);

    // R6: chunk switch at byte 256 with partial fills
    for (int i = 0; i < 512; i++) page[i] = 8'($urandom);
    fill_acc(300);
    read_six("R6 chunk switch at 256", 300);
    fill_acc(255);
    read_six("R6 one short of boundary", 255);
    fill_acc(257);
    read_six("R6 one past boundary", 257);

    // Directed corner: single set byte at last offset of each chunk
    for (int i = 0; i < 512; i++) page[i] = 8'h00;
    page[255] = 8'h80;
    page[511] = 8'h01;
    fill_acc(512);
    read_six("R4 last offsets", 512);

    // R11: single flipped bit changes exactly 11 parity bits
    for (int i = 0; i < 512; i++) page[i] = 8'($urandom);
    begin
      int fi = int'($urandom_range(256, 511));
      int fb = int'($urandom_range(0, 7));
      orig = ref_par(1, 512);
      page[fi][fb] = ~page[fi][fb];
      fill_acc(512);
      read_six("R4 flipped page", 512);
      now = {got[5], got[3], got[4]};
      chk("R11 hamming distance", 32'($countones(orig ^ now)), 32'd11);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule